// File: doc/BRIEF.md
# RS-485 Multidrop Address Filter and Driver-Direction Control

This block sits beside one UART channel. On the receive side it takes 9-bit characters from the deserializer. The top bit of each character marks it as a station address or as data. The block decides which characters reach the receive FIFO. It can work in a host-managed mode, where software opens and closes the receiver. It can also work in an automatic mode, where the receiver opens on its own when an address matches a programmed station address and closes on any other address.

Accepted address characters are stored with the address marker moved into the FIFO's error-flag position, and a line-status interrupt pulse is raised. When multidrop filtering is off, characters pass through unchanged together with their normal error flag.

On the transmit side, the block can drive the line driver's enable (the RTS pin, active low) from transmitter activity. The enable is asserted on a write to the TX FIFO. It is released at the end of a stop bit once the FIFO and the shifter are both empty. A polarity control inverts the driven level. While automatic direction control is on, it takes precedence over the manual RTS request and over the flow-control RTS request.

Top module: `mdrop_ctrl`

## Requirements
- R1: Bit DATA_W of `rx_char` set to 1 marks an address character; set to 0 it marks a data character. Bits DATA_W-1:0 are the payload. `md_sel` selects the mode: 0 = pass-through, 1 = host-managed, 2 or 3 = automatic.
- R2: In pass-through mode, every strobed character is pushed one clock after `rx_valid`. The pushed data is the payload and `push_err` equals `rx_perr`. No line-status pulse is raised.
- R3: In host-managed mode, a data character is pushed with `push_err`=0 when `host_rx_en` is 1, and it is discarded when `host_rx_en` is 0.
- R4: In host-managed mode, an address character is always pushed with `push_err`=1, and `lsr_irq` pulses in the same cycle, whatever the value of `host_rx_en`.
- R5: In automatic mode, an address character equal to `match_addr` is pushed with `push_err`=1, pulses `lsr_irq`, and opens the receiver.
- R6: In automatic mode, data characters are pushed (with `push_err`=0) only while the receiver is open. After reset the receiver is closed. Any cycle with `md_sel` outside automatic mode also closes it.
- R7: In automatic mode, a non-matching address character is discarded and closes an open receiver.
- R8: With `dir_auto_en`=1, a `tx_wr` pulse makes the driver active from the next clock. While active and `rts_invert`=0, `rts_n` is 0.
- R9: The active driver state ends only in a clock where `tx_stop_end` and `tx_idle` are both 1. A stop-bit end while the transmitter is not idle, or idle without a stop-bit end, keeps it active.
- R10: With `rts_invert`=1, the automatic `rts_n` level is inverted: 1 while active, 0 when released.
- R11: With `dir_auto_en`=1, `man_rts` and `flow_rts` have no effect on `rts_n`. With `dir_auto_en`=0, `rts_n` is 0 exactly when both are 1.
- R12: During and just after reset, `push_valid` and `lsr_irq` are 0 and `rts_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Received-character strobe |
| rx_char | input | DATA_W+1 | Received character; top bit is the address marker |
| rx_perr | input | 1 | Normal error flag from the deserializer |
| match_addr | input | DATA_W | Programmed station address |
| md_sel | input | 2 | Multidrop mode select |
| host_rx_en | input | 1 | Host receiver enable (host-managed mode) |
| push_valid | output | 1 | RX FIFO write strobe |
| push_data | output | DATA_W | RX FIFO write data |
| push_err | output | 1 | RX FIFO error flag written with the data |
| lsr_irq | output | 1 | Line-status interrupt pulse |
| dir_auto_en | input | 1 | Automatic driver-direction control enable |
| rts_invert | input | 1 | Invert the automatic RTS level |
| man_rts | input | 1 | Manual RTS request |
| flow_rts | input | 1 | Flow-control RTS request |
| tx_wr | input | 1 | TX FIFO write strobe |
| tx_stop_end | input | 1 | Pulse at the end of each transmitted stop bit |
| tx_idle | input | 1 | TX FIFO and shift register both empty |
| rts_n | output | 1 | RTS / driver-enable pin, active low |

## Verification
The hardest state to reach is an open automatic-mode receiver that is then closed by a foreign address. To be visible, the closure needs a matching address first, then data that is accepted, then a non-matching address, and then data that must vanish. The stimulus walks this sequence in order. It also repeats the opening after a short excursion out of automatic mode, to show that the excursion alone closes the receiver. On the transmit side, the driver release needs a stop-bit end that coincides with an idle transmitter. The bench first applies each of the two conditions alone, and only then both together.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
   typedef enum logic [1:0] {
      MD_PASS     = 2'd0,
      MD_HOST     = 2'd1,
      MD_AUTO     = 2'd2,
      MD_AUTO_ALT = 2'd3
   } md_mode_e;
endpackage

// File: rtl/mdrop_rx_filter.sv
module mdrop_rx_filter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W:0]   rx_char,
   input  logic              rx_perr,
   input  logic [DATA_W-1:0] match_addr,
   input  logic [1:0]        md_sel,
   input  logic              host_rx_en,
   output logic              push_valid,
   output logic [DATA_W-1:0] push_data,
   output logic              push_err,
   output logic              lsr_irq
);
   import mdrop_pkg::*;

   localparam int MARK_BIT = DATA_W;

   md_mode_e          mode;
   logic              is_addr, addr_hit, is_auto;
   logic [DATA_W-1:0] payload;
   logic              open_q, open_d;
   logic              take, take_err, take_irq;

   assign mode     = md_mode_e'(md_sel);
   assign is_addr  = rx_char[MARK_BIT];
   assign payload  = rx_char[DATA_W-1:0];
   assign addr_hit = (payload == match_addr);
   assign is_auto  = (mode == MD_AUTO) || (mode == MD_AUTO_ALT);

   always_comb begin
      take     = 1'b0;
      take_err = 1'b0;
      take_irq = 1'b0;
      open_d   = is_auto ? open_q : 1'b0;
      if (rx_valid) begin
         case (mode)
            MD_PASS: begin
               take     = 1'b1;
               take_err = rx_perr;
            end
            MD_HOST: begin
               if (is_addr) begin
                  take     = 1'b1;
                  take_err = 1'b1;
                  take_irq = 1'b1;
               end else begin
                  take = host_rx_en;
               end
            end
            default: begin
               if (is_addr) begin
                  if (addr_hit) begin
                     open_d   = 1'b1;
                     take     = 1'b1;
                     take_err = 1'b1;
                     take_irq = 1'b1;
                  end else begin
                     open_d = 1'b0;
                  end
               end else begin
                  take = open_q;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q     <= 1'b0;
         push_valid <= 1'b0;
         push_err   <= 1'b0;
         lsr_irq    <= 1'b0;
         push_data  <= '0;
      end else begin
         open_q     <= open_d;
         push_valid <= take;
         push_err   <= take & take_err;
         lsr_irq    <= take_irq;
         if (take) push_data <= payload;
      end
   end

   a_r3_host_data_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && md_sel == 2'd1 && !rx_char[MARK_BIT] && !host_rx_en) |=> !push_valid);

   a_r4_host_addr_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && md_sel == 2'd1 && rx_char[MARK_BIT]) |=> (push_valid && push_err && lsr_irq));

   a_r6_auto_closed_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && md_sel[1] && !rx_char[MARK_BIT] && !open_q) |=> !push_valid);

   a_r7_auto_miss_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && md_sel[1] && rx_char[MARK_BIT] && rx_char[DATA_W-1:0] != match_addr)
      |=> (!push_valid && !open_q));

   a_r5_irq_with_push: assert property (@(posedge clk) disable iff (!rst_n)
      lsr_irq |-> (push_valid && push_err));
endmodule

// File: rtl/mdrop_dir_ctrl.sv
module mdrop_dir_ctrl #(
   parameter bit RTS_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_auto_en,
   input  logic rts_invert,
   input  logic man_rts,
   input  logic flow_rts,
   input  logic tx_wr,
   input  logic tx_stop_end,
   input  logic tx_idle,
   output logic rts_n
);
   logic busy_q;
   logic rts_next;
   logic drain_done;

   assign drain_done = tx_stop_end & tx_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              busy_q <= 1'b0;
      else if (!dir_auto_en)   busy_q <= 1'b0;
      else if (tx_wr)          busy_q <= 1'b1;
      else if (drain_done)     busy_q <= 1'b0;
   end

   always_comb begin
      if (dir_auto_en) rts_next = busy_q ? rts_invert : ~rts_invert;
      else             rts_next = ~(man_rts & flow_rts);
   end

   generate
      if (RTS_REG) begin : g_rts_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rts_n <= 1'b1;
            else        rts_n <= rts_next;
         end
      end else begin : g_rts_comb
         assign rts_n = rts_next;

         a_r10_active_level: assert property (@(posedge clk) disable iff (!rst_n)
            (dir_auto_en && busy_q) |-> (rts_n == rts_invert));
      end
   endgenerate

   a_r8_write_activates: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_auto_en && tx_wr) |=> busy_q);

   a_r9_hold_until_drain: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && dir_auto_en && !(tx_stop_end && tx_idle)) |=> busy_q);
endmodule

// File: rtl/mdrop_ctrl.sv
module mdrop_ctrl #(
   parameter int DATA_W  = 8,
   parameter bit RTS_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W:0]   rx_char,
   input  logic              rx_perr,
   input  logic [DATA_W-1:0] match_addr,
   input  logic [1:0]        md_sel,
   input  logic              host_rx_en,
   output logic              push_valid,
   output logic [DATA_W-1:0] push_data,
   output logic              push_err,
   output logic              lsr_irq,
   input  logic              dir_auto_en,
   input  logic              rts_invert,
   input  logic              man_rts,
   input  logic              flow_rts,
   input  logic              tx_wr,
   input  logic              tx_stop_end,
   input  logic              tx_idle,
   output logic              rts_n
);
   generate
      if (DATA_W < 5 || DATA_W > 16) begin : g_bad_width
         $error("mdrop_ctrl: DATA_W must lie in 5..16");
      end
   endgenerate

   mdrop_rx_filter #(.DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
      .rx_perr(rx_perr), .match_addr(match_addr), .md_sel(md_sel),
      .host_rx_en(host_rx_en), .push_valid(push_valid), .push_data(push_data),
      .push_err(push_err), .lsr_irq(lsr_irq)
   );

   mdrop_dir_ctrl #(.RTS_REG(RTS_REG)) u_dir (
      .clk(clk), .rst_n(rst_n), .dir_auto_en(dir_auto_en), .rts_invert(rts_invert),
      .man_rts(man_rts), .flow_rts(flow_rts), .tx_wr(tx_wr),
      .tx_stop_end(tx_stop_end), .tx_idle(tx_idle), .rts_n(rts_n)
   );
endmodule

// File: tb/mdrop_ctrl_tb.sv
module mdrop_ctrl_tb;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_valid = 1'b0;
   logic [DW:0]   rx_char = '0;
   logic          rx_perr = 1'b0;
   logic [DW-1:0] match_addr = 8'h42;
   logic [1:0]    md_sel = 2'd0;
   logic          host_rx_en = 1'b0;
   logic          push_valid, push_err, lsr_irq, rts_n;
   logic [DW-1:0] push_data;
   logic          dir_auto_en = 1'b0, rts_invert = 1'b0, man_rts = 1'b0, flow_rts = 1'b0;
   logic          tx_wr = 1'b0, tx_stop_end = 1'b0, tx_idle = 1'b1;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   string cur_tag = "R12";

   typedef struct { logic [DW-1:0] d; logic e; logic i; string tag; } exp_t;
   exp_t q[$];

   always #10 clk = ~clk;

   mdrop_ctrl #(.DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
      .rx_perr(rx_perr), .match_addr(match_addr), .md_sel(md_sel),
      .host_rx_en(host_rx_en), .push_valid(push_valid), .push_data(push_data),
      .push_err(push_err), .lsr_irq(lsr_irq), .dir_auto_en(dir_auto_en),
      .rts_invert(rts_invert), .man_rts(man_rts), .flow_rts(flow_rts),
      .tx_wr(tx_wr), .tx_stop_end(tx_stop_end), .tx_idle(tx_idle), .rts_n(rts_n)
   );

   // Monitor: compares every push against the head of the expected queue
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (push_valid) begin
            n_cmp++;
            if (q.size() == 0) begin
               n_bad++;
               $display("FAIL %s: unexpected push data=%h err=%b (expected none)", cur_tag, push_data, push_err);
            end else begin
               exp_t x;
               x = q.pop_front();
               if (push_data !== x.d || push_err !== x.e || lsr_irq !== x.i) begin
                  n_bad++;
                  $display("FAIL %s: got d=%h e=%b i=%b expected d=%h e=%b i=%b",
                           x.tag, push_data, push_err, lsr_irq, x.d, x.e, x.i);
               end
            end
         end else if (lsr_irq) begin
            n_cmp++; n_bad++;
            $display("FAIL %s: lsr_irq=1 without push (expected 0)", cur_tag);
         end
      end
   end

   task automatic send(input logic [DW:0] ch, input logic perr, input bit exp_push,
                       input logic exp_err, input logic exp_irq, input string tag);
      @(negedge clk);
      cur_tag  = tag;
      rx_char  = ch;
      rx_perr  = perr;
      rx_valid = 1'b1;
      if (exp_push) begin
         exp_t x;
         x.d = ch[DW-1:0]; x.e = exp_err; x.i = exp_irq; x.tag = tag;
         q.push_back(x);
      end
      @(negedge clk);
      rx_valid = 1'b0;
      if (!exp_push) begin
         n_cmp++;
         if (push_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL %s: push_valid=%b after dropped char %h (expected 0)", tag, push_valid, ch);
         end
      end
   endtask

   task automatic chk_rts(input logic exp, input string tag);
      @(negedge clk);
      n_cmp++;
      if (rts_n !== exp) begin
         n_bad++;
         $display("FAIL %s: rts_n=%b expected %b", tag, rts_n, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      n_cmp++;
      if (push_valid !== 1'b0 || lsr_irq !== 1'b0 || rts_n !== 1'b1) begin
         n_bad++;
         $display("FAIL R12: in reset pv=%b irq=%b rts_n=%b expected 0 0 1", push_valid, lsr_irq, rts_n);
      end
      rst_n = 1'b1;
      chk_rts(1'b1, "R12");

      // pass-through (R2, R1)
      md_sel = 2'd0;
      send(9'h0A5, 1'b0, 1, 1'b0, 1'b0, "R2");
      send(9'h13C, 1'b1, 1, 1'b1, 1'b0, "R2");
      send(9'h07E, 1'b1, 1, 1'b1, 1'b0, "R1");

      // host-managed (R3, R4)
      md_sel = 2'd1; host_rx_en = 1'b0;
      send(9'h055, 1'b0, 0, 1'b0, 1'b0, "R3");
      send(9'h142, 1'b0, 1, 1'b1, 1'b1, "R4");
      host_rx_en = 1'b1;
      send(9'h066, 1'b1, 1, 1'b0, 1'b0, "R3");
      send(9'h177, 1'b0, 1, 1'b1, 1'b1, "R4");
      host_rx_en = 1'b0;
      send(9'h067, 1'b0, 0, 1'b0, 1'b0, "R3");

      // automatic (R5, R6, R7)
      md_sel = 2'd2;
      send(9'h011, 1'b0, 0, 1'b0, 1'b0, "R6");
      send(9'h143, 1'b0, 0, 1'b0, 1'b0, "R7");
      send(9'h012, 1'b0, 0, 1'b0, 1'b0, "R7");
      send(9'h142, 1'b0, 1, 1'b1, 1'b1, "R5");
      send(9'h022, 1'b1, 1, 1'b0, 1'b0, "R6");
      send(9'h150, 1'b0, 0, 1'b0, 1'b0, "R7");
      send(9'h033, 1'b0, 0, 1'b0, 1'b0, "R7");
      send(9'h142, 1'b0, 1, 1'b1, 1'b1, "R5");
      send(9'h044, 1'b0, 1, 1'b0, 1'b0, "R6");
      @(negedge clk); md_sel = 2'd0;
      @(negedge clk); md_sel = 2'd2;
      send(9'h055, 1'b0, 0, 1'b0, 1'b0, "R6");
      md_sel = 2'd3; match_addr = 8'h99;
      send(9'h199, 1'b0, 1, 1'b1, 1'b1, "R5");
      send(9'h0AB, 1'b0, 1, 1'b0, 1'b0, "R6");

      // direction control (R8..R11)
      dir_auto_en = 1'b0; man_rts = 1'b1; flow_rts = 1'b1;
      chk_rts(1'b0, "R11");
      flow_rts = 1'b0;
      chk_rts(1'b1, "R11");
      flow_rts = 1'b1; dir_auto_en = 1'b1;
      chk_rts(1'b1, "R11");
      tx_wr = 1'b1; tx_idle = 1'b0;
      @(negedge clk); tx_wr = 1'b0;
      n_cmp++;
      if (rts_n !== 1'b0) begin n_bad++; $display("FAIL R8: rts_n=%b expected 0", rts_n); end
      man_rts = 1'b0;
      chk_rts(1'b0, "R11");
      tx_stop_end = 1'b1; tx_idle = 1'b0;
      @(negedge clk); tx_stop_end = 1'b0;
      chk_rts(1'b0, "R9");
      tx_idle = 1'b1;
      chk_rts(1'b0, "R9");
      tx_stop_end = 1'b1;
      @(negedge clk); tx_stop_end = 1'b0;
      n_cmp++;
      if (rts_n !== 1'b1) begin n_bad++; $display("FAIL R9: rts_n=%b expected 1", rts_n); end
      rts_invert = 1'b1;
      chk_rts(1'b0, "R10");
      tx_wr = 1'b1; tx_idle = 1'b0;
      @(negedge clk); tx_wr = 1'b0;
      n_cmp++;
      if (rts_n !== 1'b1) begin n_bad++; $display("FAIL R10: rts_n=%b expected 1", rts_n); end
      tx_idle = 1'b1; tx_stop_end = 1'b1;
      @(negedge clk); tx_stop_end = 1'b0;
      n_cmp++;
      if (rts_n !== 1'b0) begin n_bad++; $display("FAIL R10: rts_n=%b expected 0", rts_n); end

      repeat (3) @(negedge clk);
      n_cmp++;
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL R2: %0d expected pushes never seen (expected 0)", q.size());
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL R12: watchdog expired, actual hung, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule